// File: doc/BRIEF.md
# Daily Event Bitmap Logger

This block keeps a record of the seconds of a day in which motion was seen. Each second has one bit: a 1 means at least one event strobe came in during that second. Two banks of on-chip memory hold the record. One bank fills with today's events, addressed by the time-of-day second count. The other bank holds the completed previous day, and a download port reads it one bit at a time. A day-rollover pulse swaps the roles of the two banks. The bank that becomes active starts out empty.

Bits are packed into wide words so that the arrays stay small and map onto block RAM. A word accumulator gathers the bits of the current word and writes the whole word once, when the second count moves into another word or the day rolls over. A per-word valid tag, one per bank word, marks which words were written today. Clearing the tags of one bank empties it in a single cycle, so no sweep is needed. A parameter selects half resolution, with one bit for each pair of seconds.

The seconds index is assumed not to decrease within a day. A word that is left and later entered again is rewritten with only the bits gathered on the second visit.

Top module: `event_bitmap_logger`

## Requirements
- R1: After reset, `rd_bit` is 0. A read of the download bank before any rollover returns 0 at every address.
- R2: An `ev_strobe` with a valid `sec_in` records a 1 at that second's slot. Repeated strobes in the same second leave a single 1. Neighbouring slots stay 0.
- R3: A `sec_in` of `DAY_SECONDS` (86400) or more is ignored. A strobe at such a value records nothing and does not disturb bits gathered earlier.
- R4: A one-cycle `rollover` pulse swaps the two banks at that clock edge. The day that just ended becomes readable from the next cycle.
- R5: The bank that becomes active at a rollover starts empty. Bits it held two days earlier no longer read back after the following rollover.
- R6: A read issued with `rd_en` high at one clock edge shows its bit on `rd_bit` until the next edge. `rd_bit` is 0 when `rd_en` was low at the previous edge, or when `rd_addr` was at or above the slot count (86400, or 43200 at half resolution).
- R7: Events recorded today do not change what the download port returns for yesterday.
- R8: With `HALF_RES` = 1, slot = `sec_in` >> 1, so seconds 2k and 2k+1 share slot k. There are 43200 slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_in | input | 17 | Seconds elapsed since midnight |
| rollover | input | 1 | One-cycle day-change pulse; swaps the banks |
| ev_strobe | input | 1 | Motion event in the current second |
| rd_en | input | 1 | Download read request |
| rd_addr | input | 17 | Slot index to read from yesterday's bank |
| rd_bit | output | 1 | Read result, one cycle after the request |

## Verification
On every cycle the assertions check four things: that a strobe lands in the word accumulator at the right bit, that an out-of-range second leaves the accumulator and write port alone, that each rollover flips the active bank, and that `rd_bit` is 0 after an idle or out-of-range request. Some behaviours show up only in the bench's scenarios, because they need a whole day written, swapped and read back through the ports: bits surviving a swap, the reused bank starting empty, today's writes leaving yesterday untouched, and two seconds folding into one slot at half resolution.

// File: rtl/dlog_pkg.sv
// Shared constants and helpers for the event bitmap logger.
package dlog_pkg;
    localparam int SEC_W = 17;

    // Integer division rounded up.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction
endpackage

// File: rtl/dlog_index.sv
// Splits a 17-bit index into a word number and a bit position.
// It optionally shifts the index right first (half resolution).
// Assumes WORD_W is a power of two. ok is 0 when value >= LIMIT.
module dlog_index #(
    parameter int SHIFT  = 0,
    parameter int LIMIT  = 86400,
    parameter int WORD_W = 64,
    parameter int WIDX_W = 11,
    localparam int SEL_W = $clog2(WORD_W)
) (
    input  logic [dlog_pkg::SEC_W-1:0] value,
    output logic                       ok,
    output logic [WIDX_W-1:0]          word,
    output logic [SEL_W-1:0]           sel
);
    logic [dlog_pkg::SEC_W-1:0] slot;

    // Range check, then split the slot number.
    always_comb begin
        ok   = (32'(value) < LIMIT);
        slot = value >> SHIFT;
        word = WIDX_W'(slot >> SEL_W);
        sel  = slot[SEL_W-1:0];
    end
endmodule

// File: rtl/dlog_accum.sv
// Gathers event bits for the word the second counter is in.
// It emits a whole-word write when the counter enters another word or
// the day rolls over. Assumes the seconds index does not decrease
// within a day.
module dlog_accum #(
    parameter int WORD_W = 64,
    parameter int WIDX_W = 11,
    localparam int SEL_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rollover,
    input  logic              ev_strobe,
    input  logic              cur_ok,
    input  logic [WIDX_W-1:0] cur_word,
    input  logic [SEL_W-1:0]  cur_sel,
    output logic              wr_en,
    output logic [WIDX_W-1:0] wr_word,
    output logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] acc_bits
);
    logic              live_q;
    logic [WIDX_W-1:0] word_q;
    logic [WORD_W-1:0] acc_q;
    logic              load;
    logic [WORD_W-1:0] fresh;

    // Decide between flushing and reloading, and build the new word.
    always_comb begin
        load    = rollover || (cur_ok && (!live_q || cur_word != word_q));
        wr_en   = live_q && (rollover || (cur_ok && cur_word != word_q));
        wr_word = word_q;
        wr_data = acc_q;
        fresh   = '0;
        if (cur_ok && ev_strobe) fresh[cur_sel] = 1'b1;
        acc_bits = acc_q;
    end

    // Accumulator state: reload on a word change or rollover, else OR in events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= 1'b0;
            word_q <= '0;
            acc_q  <= '0;
        end else if (load) begin
            live_q <= cur_ok;
            word_q <= cur_word;
            acc_q  <= fresh;
        end else if (cur_ok && ev_strobe) begin
            acc_q[cur_sel] <= 1'b1;
        end
    end
endmodule

// File: rtl/dlog_bank.sv
// One day bank: a packed-word array with one write port and one
// registered read port, plus a valid tag per word. Clearing all tags
// at once empties the bank. Array contents have no reset, so block RAM
// can be inferred; unwritten words are masked by their tags.
module dlog_bank #(
    parameter int WORDS  = 1350,
    parameter int WORD_W = 64,
    parameter int WIDX_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_tags,
    input  logic              wr_en,
    input  logic [WIDX_W-1:0] wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [WIDX_W-1:0] rd_idx,
    output logic [WORD_W-1:0] rd_word,
    output logic              rd_tag
);
    logic [WORD_W-1:0] mem [WORDS];
    logic [WORDS-1:0]  tag_q;

    // Memory write and registered read, free of reset for RAM inference.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
        if (rd_en) rd_word <= mem[rd_idx];
    end

    // Word valid tags: cleared as a block, set per written word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q  <= '0;
            rd_tag <= 1'b0;
        end else begin
            if (clr_tags)   tag_q <= '0;
            else if (wr_en) tag_q[wr_idx] <= 1'b1;
            if (rd_en) rd_tag <= tag_q[rd_idx];
        end
    end
endmodule

// File: rtl/event_bitmap_logger.sv
// Per-second motion bitmap across two day banks that swap on rollover.
// Today's bank is written through a word accumulator; the other bank is
// read one bit at a time with one cycle of latency. Assumes rollover is
// a single-cycle pulse and sec_in does not decrease within a day.
module event_bitmap_logger #(
    parameter int DAY_SECONDS = 86400,
    parameter int HALF_RES    = 0,
    parameter int WORD_W      = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [16:0] sec_in,
    input  logic        rollover,
    input  logic        ev_strobe,
    input  logic        rd_en,
    input  logic [16:0] rd_addr,
    output logic        rd_bit
);
    localparam int ENTRIES = DAY_SECONDS >> HALF_RES;
    localparam int WORDS   = dlog_pkg::ceil_div(ENTRIES, WORD_W);
    localparam int WIDX_W  = $clog2(WORDS);
    localparam int SEL_W   = $clog2(WORD_W);

    logic              cur_ok, rd_ok;
    logic [WIDX_W-1:0] cur_word, rd_word_idx, wr_word;
    logic [SEL_W-1:0]  cur_sel, rd_sel;
    logic              wr_en;
    logic [WORD_W-1:0] wr_data, acc_bits;
    logic              active_q;
    logic              rd_ok_q, rd_bank_q;
    logic [SEL_W-1:0]  rd_sel_q;
    logic [WORD_W-1:0] bank_word [2];
    logic [1:0]        bank_tag;

    dlog_index #(.SHIFT(HALF_RES), .LIMIT(DAY_SECONDS), .WORD_W(WORD_W), .WIDX_W(WIDX_W))
        u_wr_index (.value(sec_in), .ok(cur_ok), .word(cur_word), .sel(cur_sel));

    dlog_index #(.SHIFT(0), .LIMIT(ENTRIES), .WORD_W(WORD_W), .WIDX_W(WIDX_W))
        u_rd_index (.value(rd_addr), .ok(rd_ok), .word(rd_word_idx), .sel(rd_sel));

    dlog_accum #(.WORD_W(WORD_W), .WIDX_W(WIDX_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .rollover(rollover), .ev_strobe(ev_strobe),
        .cur_ok(cur_ok), .cur_word(cur_word), .cur_sel(cur_sel),
        .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data), .acc_bits(acc_bits)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic is_active;
        assign is_active = (active_q == 1'(b));
        dlog_bank #(.WORDS(WORDS), .WORD_W(WORD_W), .WIDX_W(WIDX_W)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .clr_tags(rollover && !is_active),
            .wr_en(wr_en && is_active), .wr_idx(wr_word), .wr_data(wr_data),
            .rd_en(rd_en && rd_ok && !is_active), .rd_idx(rd_word_idx),
            .rd_word(bank_word[b]), .rd_tag(bank_tag[b])
        );
    end

    // Active bank pointer: flips on each rollover pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)        active_q <= 1'b0;
        else if (rollover) active_q <= !active_q;
    end

    // Read side-band: remember which bank and bit the pending read wants.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ok_q   <= 1'b0;
            rd_bank_q <= 1'b0;
            rd_sel_q  <= '0;
        end else begin
            rd_ok_q   <= rd_en && rd_ok;
            rd_bank_q <= !active_q;
            rd_sel_q  <= rd_sel;
        end
    end

    // Output select: a valid tag and a pending read are both needed.
    always_comb rd_bit = rd_ok_q && bank_tag[rd_bank_q] && bank_word[rd_bank_q][rd_sel_q];
endmodule

// File: rtl/event_bitmap_logger_checker.sv
// Cycle-level properties of the event bitmap logger, bound to every instance.
module event_bitmap_logger_checker #(
    parameter int DAY_SECONDS = 86400,
    parameter int HALF_RES    = 0,
    parameter int WORD_W      = 64,
    localparam int ENTRIES    = DAY_SECONDS >> HALF_RES,
    localparam int SEL_W      = $clog2(WORD_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [16:0]       sec_in,
    input logic              rollover,
    input logic              ev_strobe,
    input logic              rd_en,
    input logic [16:0]       rd_addr,
    input logic              rd_bit,
    input logic              active_q,
    input logic              wr_en,
    input logic [SEL_W-1:0]  cur_sel,
    input logic [WORD_W-1:0] acc_bits
);
    assert_strobe_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_strobe && 32'(sec_in) < DAY_SECONDS) |=> acc_bits[$past(cur_sel)]);

    assert_bad_second_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rollover && 32'(sec_in) >= DAY_SECONDS) |=> $stable(acc_bits));

    assert_bad_second_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rollover && 32'(sec_in) >= DAY_SECONDS) |-> !wr_en);

    assert_swap_on_rollover_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rollover |=> (active_q != $past(active_q)));

    assert_idle_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_bit);

    assert_range_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(rd_addr) >= ENTRIES) |=> !rd_bit);
endmodule

bind event_bitmap_logger event_bitmap_logger_checker #(
    .DAY_SECONDS(DAY_SECONDS), .HALF_RES(HALF_RES), .WORD_W(WORD_W)
) u_checker (
    .clk(clk), .rst_n(rst_n), .sec_in(sec_in), .rollover(rollover),
    .ev_strobe(ev_strobe), .rd_en(rd_en), .rd_addr(rd_addr), .rd_bit(rd_bit),
    .active_q(active_q), .wr_en(wr_en), .cur_sel(cur_sel), .acc_bits(acc_bits)
);

// File: tb/test_event_bitmap_logger.sv
`timescale 1ns/1ps
module test_event_bitmap_logger;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    // full-resolution instance signals
    logic [16:0] sec_f = '0, addr_f = '0;
    logic        roll_f = 0, ev_f = 0, ren_f = 0, bit_f;
    // half-resolution instance signals
    logic [16:0] sec_h = '0, addr_h = '0;
    logic        roll_h = 0, ev_h = 0, ren_h = 0, bit_h;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    event_bitmap_logger i_event_bitmap_logger (
        .clk(clk), .rst_n(rst_n), .sec_in(sec_f), .rollover(roll_f),
        .ev_strobe(ev_f), .rd_en(ren_f), .rd_addr(addr_f), .rd_bit(bit_f));

    event_bitmap_logger #(.HALF_RES(1)) i_event_bitmap_logger_half (
        .clk(clk), .rst_n(rst_n), .sec_in(sec_h), .rollover(roll_h),
        .ev_strobe(ev_h), .rd_en(ren_h), .rd_addr(addr_h), .rd_bit(bit_h));

    // Day-0 event seconds: includes repeats and out-of-range values.
    localparam int NEV = 11;
    localparam int unsigned EV_SEC [NEV] =
        '{0, 1, 63, 64, 200, 200, 200, 5000, 86399, 86400, 131071};
    // Read-back vectors after the first rollover: slot and expected bit.
    localparam int NRD = 16;
    localparam int unsigned RD_ADDR [NRD] =
        '{0, 1, 2, 62, 63, 64, 65, 199, 200, 201, 4999, 5000, 86398, 86399, 86400, 131071};
    localparam bit RD_EXP [NRD] =
        '{1, 1, 0, 0, 1, 1, 0, 0, 1, 0, 0, 1, 0, 1, 0, 0};

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic strobe(input bit half, input int unsigned s);
        @(negedge clk);
        if (half) begin sec_h = 17'(s); ev_h = 1; end
        else      begin sec_f = 17'(s); ev_f = 1; end
        @(negedge clk);
        ev_h = 0; ev_f = 0;
    endtask

    task automatic roll(input bit half);
        @(negedge clk);
        if (half) roll_h = 1; else roll_f = 1;
        @(negedge clk);
        roll_h = 0; roll_f = 0;
    endtask

    task automatic read_chk(input bit half, input int unsigned a, input logic exp, input string req);
        @(negedge clk);
        if (half) begin addr_h = 17'(a); ren_h = 1; end
        else      begin addr_f = 17'(a); ren_f = 1; end
        @(negedge clk);
        ren_h = 0; ren_f = 0;
        check(req, half ? bit_h : bit_f, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: an overlong run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset output", bit_f, 1'b0);
        read_chk(0, 0, 1'b0, "R1 empty download bank");
        read_chk(0, 86399, 1'b0, "R1 empty download bank end");

        // Table walk: record day 0, swap, read back.
        for (int i = 0; i < NEV; i++) strobe(0, EV_SEC[i]);
        roll(0);
        for (int i = 0; i < NRD; i++)
            read_chk(0, RD_ADDR[i], RD_EXP[i], "R2 R3 R4 R6 table read");

        // R6: idle cycle after a read that returned 1 gives 0.
        read_chk(0, 0, 1'b1, "R6 read one");
        @(negedge clk);
        check("R6 idle read is zero", bit_f, 1'b0);

        // R7: today's events do not show in yesterday's bank.
        strobe(0, 10);
        strobe(0, 3000);
        read_chk(0, 10, 1'b0, "R7 today hidden");
        read_chk(0, 0, 1'b1, "R7 yesterday intact");
        read_chk(0, 3000, 1'b0, "R7 today hidden 2");

        // R4/R5: second swap shows day 1 only.
        roll(0);
        read_chk(0, 10, 1'b1, "R4 day1 bit");
        read_chk(0, 3000, 1'b1, "R4 day1 bit 2");
        read_chk(0, 0, 1'b0, "R5 day1 bank fresh");

        // R5: the reused bank no longer shows day 0 after the third swap.
        strobe(0, 64);
        roll(0);
        read_chk(0, 0, 1'b0, "R5 day0 bit cleared");
        read_chk(0, 63, 1'b0, "R5 day0 bit cleared 2");
        read_chk(0, 64, 1'b1, "R5 day2 bit");
        read_chk(0, 86399, 1'b0, "R5 day0 end cleared");

        // R8: half resolution folds second pairs.
        strobe(1, 10);
        strobe(1, 11);
        strobe(1, 21);
        strobe(1, 86399);
        strobe(1, 86400);
        roll(1);
        read_chk(1, 5, 1'b1, "R8 pair slot");
        read_chk(1, 10, 1'b1, "R8 slot of second 21");
        read_chk(1, 4, 1'b0, "R8 empty slot");
        read_chk(1, 11, 1'b0, "R8 no slot per second");
        read_chk(1, 43199, 1'b1, "R8 last slot");
        read_chk(1, 43200, 1'b0, "R8 R6 slot out of range");

        finish_run();
    end
endmodule